// File: doc/BRIEF.md
# Status Register Write-Protect Gate

This block decides whether a write to the nonvolatile bits of a serial memory's status register may take effect. A serial front-end marks the status-write sequence with an activity flag and, when the device is deselected, issues a write-cycle start strobe with the proposed register value. The gate combines an active-low protect pin with a lock-enable bit held in the register. If the lock bit is set and the pin is seen low at any time during the sequence, the nonvolatile part of the update is discarded. If the lock bit is clear, the pin has no effect, so a board with the pin tied low can still write the register.

The verdict is fixed in the cycle the write cycle starts. After that, the pin is ignored for as long as the internal write cycle runs. Volatile bits of the proposed value are loaded at the start without gating. The nonvolatile bits are loaded when the write cycle ends, and only if the verdict allowed it.

Top module: `sr_protect_gate`

## Requirements
- R1: After reset, `status_o` equals RESET_VAL (all zeros by default), and `wr_busy_o` and `nv_commit_o` are low.
- R2: While the stored lock bit (bit 7 of `status_o`) is 0, the level of `prot_n` has no effect, and a status write updates the nonvolatile bits (mask 0x8C: bits 7, 3, 2).
- R3: With the stored lock bit at 1 and `prot_n` high throughout the sequence, the nonvolatile bits are updated.
- R4: With the stored lock bit at 1, `prot_n` low in any cycle while `sr_wr_active_i` is high blocks the nonvolatile update. The pin is seen through SYNC_STAGES (2) flops. A blocked write gives no `nv_commit_o` pulse, and the nonvolatile bits change only on a commit.
- R5: A block is sticky. The pin going high again before the start still blocks the write. The block is cleared when `cs_n` rises, so the next sequence is judged on its own.
- R6: Once a write cycle has been accepted, changes on `prot_n` do not alter its outcome.
- R7: The verdict uses the lock bit already stored, not the incoming one. With the pin low, setting the lock bit from 0 succeeds, and clearing it from 1 is blocked.
- R8: The volatile bits (mask 0x03: bits 1, 0) of `sr_new_i` are loaded at the start of every accepted write, whether or not it is blocked, and change at no other time.
- R9: An accepted write keeps `wr_busy_o` high for WR_CYCLES (4) cycles. A permitted write then gives exactly one `nv_commit_o` cycle, in the same cycle the new bits appear. Start strobes while busy are ignored.
- R10: A `wr_start_i` strobe while `sr_wr_active_i` is low is ignored. It starts no write cycle and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; a rise clears the block flag |
| prot_n | input | 1 | Write-protect pin, active low |
| sr_wr_active_i | input | 1 | Status-write sequence in progress |
| wr_start_i | input | 1 | Internal write-cycle start strobe |
| sr_new_i | input | REG_W | Proposed status register value |
| nv_commit_o | output | 1 | One-cycle pulse when nonvolatile bits are written |
| wr_busy_o | output | 1 | Internal write cycle running |
| status_o | output | REG_W | Current status register |

## Verification
The bench builds the gate with the default values: an 8-bit register, lock bit 7, nonvolatile mask 0x8C, volatile mask 0x03, a two-flop pin synchronizer and a four-cycle write. With these values, a short low pulse on the pin can be placed early in a ten-cycle sequence and still pass through the synchronizer before the start. This exercises the sticky block. The short write cycle also leaves room for a pin change and a second start strobe while a write is still running.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

  typedef enum logic {
    WC_IDLE = 1'b0,
    WC_PROG = 1'b1
  } wc_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/srwp_pin_sync.sv
module srwp_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic pin_n_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign pin_n_o = pin_n_i;
    end else begin : g_sync
      logic [STAGES-1:0] sync_q;
      logic [STAGES-1:0] sync_d;

      always_comb begin
        sync_d[0] = pin_n_i;
        for (int k = 1; k < int'(STAGES); k++) begin
          sync_d[k] = sync_q[k-1];
        end
      end

      // reset to 0: the pin reads as asserted until real samples arrive
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
      end

      assign pin_n_o = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/srwp_block_tracker.sv
module srwp_block_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic seq_active_i,
  input  logic lock_i,
  input  logic pin_n_i,
  output logic deny_o
);

  logic cs_n_q;
  logic flag_q;
  logic flag_d;
  logic hit;
  logic cs_rise;

  assign hit     = seq_active_i & lock_i & ~pin_n_i;
  assign cs_rise = cs_n_i & ~cs_n_q;

  always_comb begin
    flag_d = flag_q;
    if (cs_rise)  flag_d = 1'b0;
    else if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      cs_n_q <= cs_n_i;
      flag_q <= flag_d;
    end
  end

  // a hit in the start cycle itself also counts
  assign deny_o = flag_q | hit;

endmodule

// File: rtl/srwp_write_cycle.sv
module srwp_write_cycle
  import srwp_pkg::*;
#(
  parameter int unsigned      REG_W     = 8,
  parameter logic [REG_W-1:0] NV_MASK   = 8'h8C,
  parameter logic [REG_W-1:0] VOL_MASK  = 8'h03,
  parameter logic [REG_W-1:0] RESET_VAL = '0,
  parameter int unsigned      WR_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             seq_active_i,
  input  logic             deny_i,
  input  logic [REG_W-1:0] new_i,
  output logic             busy_o,
  output logic             commit_o,
  output logic [REG_W-1:0] status_o
);

  localparam int unsigned CNT_W = cnt_width(WR_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES - 1);

  wc_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ok_q, ok_d;
  logic [REG_W-1:0] pend_q, pend_d;
  logic [REG_W-1:0] stat_q, stat_d;
  logic             commit_d, commit_q;
  logic             accept;
  logic             finish;
  logic             pend_en;
  logic             stat_en;

  assign accept  = (state_q == WC_IDLE) & start_i & seq_active_i;
  assign finish  = (state_q == WC_PROG) & (cnt_q == '0);
  assign pend_en = accept;
  assign stat_en = accept | (finish & ok_q);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    ok_d     = ok_q;
    pend_d   = pend_q;
    stat_d   = stat_q;
    commit_d = 1'b0;
    unique case (state_q)
      WC_IDLE: begin
        if (accept) begin
          state_d = WC_PROG;
          cnt_d   = CNT_LOAD;
        end
      end
      WC_PROG: begin
        if (finish) state_d = WC_IDLE;
        else        cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = WC_IDLE;
    endcase
    if (pend_en) begin
      ok_d   = ~deny_i;
      pend_d = new_i;
    end
    if (stat_en) begin
      if (accept) stat_d = (stat_q & ~VOL_MASK) | (new_i & VOL_MASK);
      else        stat_d = (stat_q & ~NV_MASK) | (pend_q & NV_MASK);
    end
    if (finish & ok_q) commit_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WC_IDLE;
      cnt_q    <= '0;
      ok_q     <= 1'b0;
      pend_q   <= '0;
      stat_q   <= RESET_VAL;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      commit_q <= commit_d;
      if (pend_en) begin
        ok_q   <= ok_d;
        pend_q <= pend_d;
      end
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign busy_o   = (state_q == WC_PROG);
  assign commit_o = commit_q;
  assign status_o = stat_q;

endmodule

// File: rtl/sr_protect_gate.sv
module sr_protect_gate #(
  parameter int unsigned      REG_W       = 8,
  parameter int unsigned      LOCK_BIT    = 7,
  parameter logic [REG_W-1:0] NV_MASK     = 8'h8C,
  parameter logic [REG_W-1:0] VOL_MASK    = 8'h03,
  parameter logic [REG_W-1:0] RESET_VAL   = '0,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      WR_CYCLES   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             prot_n,
  input  logic             sr_wr_active_i,
  input  logic             wr_start_i,
  input  logic [REG_W-1:0] sr_new_i,
  output logic             nv_commit_o,
  output logic             wr_busy_o,
  output logic [REG_W-1:0] status_o
);

  logic prot_n_s;
  logic deny;
  logic lock_stored;

  assign lock_stored = status_o[LOCK_BIT];

  srwp_pin_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n_i (prot_n),
    .pin_n_o (prot_n_s)
  );

  srwp_block_tracker u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n),
    .seq_active_i (sr_wr_active_i),
    .lock_i       (lock_stored),
    .pin_n_i      (prot_n_s),
    .deny_o       (deny)
  );

  srwp_write_cycle #(
    .REG_W     (REG_W),
    .NV_MASK   (NV_MASK),
    .VOL_MASK  (VOL_MASK),
    .RESET_VAL (RESET_VAL),
    .WR_CYCLES (WR_CYCLES)
  ) u_wc (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (wr_start_i),
    .seq_active_i (sr_wr_active_i),
    .deny_i       (deny),
    .new_i        (sr_new_i),
    .busy_o       (wr_busy_o),
    .commit_o     (nv_commit_o),
    .status_o     (status_o)
  );

endmodule

// File: rtl/sr_protect_gate_chk.sv
module sr_protect_gate_chk #(
  parameter int unsigned      REG_W    = 8,
  parameter logic [REG_W-1:0] NV_MASK  = 8'h8C,
  parameter logic [REG_W-1:0] VOL_MASK = 8'h03
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sr_wr_active_i,
  input logic             wr_start_i,
  input logic             nv_commit_o,
  input logic             wr_busy_o,
  input logic [REG_W-1:0] status_o
);

  // R9
  commit_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_commit_o |-> ($past(wr_busy_o) && !wr_busy_o));

  // R9
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_commit_o |=> !nv_commit_o);

  // R4
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_commit_o |-> ((status_o & NV_MASK) == ($past(status_o) & NV_MASK)));

  // R8
  vol_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o & VOL_MASK) |-> $rose(wr_busy_o));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy_o) |-> $past(wr_start_i && sr_wr_active_i));

endmodule

bind sr_protect_gate sr_protect_gate_chk #(
  .REG_W    (REG_W),
  .NV_MASK  (NV_MASK),
  .VOL_MASK (VOL_MASK)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sr_wr_active_i (sr_wr_active_i),
  .wr_start_i     (wr_start_i),
  .nv_commit_o    (nv_commit_o),
  .wr_busy_o      (wr_busy_o),
  .status_o       (status_o)
);

// File: tb/sr_protect_gate_tb.sv
module sr_protect_gate_tb;

  localparam int SYNC = 2;
  localparam int WRC  = 4;
  localparam int SEQ  = 10;
  localparam logic [7:0] NVM  = 8'h8C;
  localparam logic [7:0] VOLM = 8'h03;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       prot_n = 1'b1;
  logic       act = 1'b0;
  logic       start = 1'b0;
  logic [7:0] nv = 8'h00;
  logic       commit;
  logic       busy;
  logic [7:0] status;

  int total = 0;
  int bad = 0;
  int busy_seen = 0;
  int commit_seen = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  sr_protect_gate #(
    .REG_W(8), .LOCK_BIT(7), .NV_MASK(NVM), .VOL_MASK(VOLM),
    .RESET_VAL(8'h00), .SYNC_STAGES(SYNC), .WR_CYCLES(WRC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .prot_n(prot_n),
    .sr_wr_active_i(act), .wr_start_i(start), .sr_new_i(nv),
    .nv_commit_o(commit), .wr_busy_o(busy), .status_o(status)
  );

  // behavioural reference
  bit [7:0] m_stat, m_pv;
  bit       m_busy, m_ok, m_commit, m_flag, m_csq;
  int       m_cnt;
  bit       pq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 8'h00; m_pv = 8'h00; m_busy = 0; m_ok = 0;
      m_commit = 0; m_flag = 0; m_csq = 1; m_cnt = 0;
      pq.delete();
      repeat (SYNC) pq.push_back(1'b0);
    end else begin
      bit pin_seen, hit, deny;
      pin_seen = pq[0];
      hit  = act && m_stat[7] && !pin_seen;
      deny = m_flag || hit;
      m_commit = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_ok) begin
            m_stat = (m_stat & ~NVM) | (m_pv & NVM);
            m_commit = 1;
          end
        end else m_cnt--;
      end else if (start && act) begin
        m_busy = 1; m_cnt = WRC - 1; m_ok = !deny; m_pv = nv;
        m_stat = (m_stat & ~VOLM) | (nv & VOLM);
      end
      if (cs_n && !m_csq) m_flag = 0;
      else if (hit)       m_flag = 1;
      m_csq = cs_n;
      void'(pq.pop_front());
      pq.push_back(prot_n);
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison, mid-cycle after the active edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk(cur_req, {status, busy, commit}, {m_stat, m_busy, m_commit});
      if (busy) busy_seen++;
      if (commit) commit_seen++;
    end
  end

  task automatic do_seq(input logic [7:0] v, input int lo_from, input int lo_len,
                        input logic pin_post, input logic extra, input logic [7:0] v2);
    busy_seen = 0; commit_seen = 0;
    @(negedge clk); cs_n = 0; act = 1; nv = v;
    for (int i = 0; i < SEQ; i++) begin
      prot_n = (i >= lo_from && i < lo_from + lo_len) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    cs_n = 1; start = 1; prot_n = pin_post;
    @(negedge clk);
    start = extra; act = extra; nv = v2;
    @(negedge clk);
    start = 0; act = 0;
    repeat (WRC + 3) @(negedge clk);
    prot_n = 1;
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic end_check(input string req, input logic [7:0] exp, input int exp_commit);
    @(posedge clk); #6;
    chk(req, status, exp);
    chk("R9", busy_seen, WRC);
    chk(req, commit_seen, exp_commit);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {status, busy, commit}, 10'h000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 lock clear, pin low all through: write goes in
    cur_req = "R2";
    do_seq(8'h0C, 0, SEQ, 1'b1, 1'b0, 8'h00);
    end_check("R2", 8'h0C, 1);

    // R7 set lock with pin low: stored lock is 0, so allowed
    cur_req = "R7";
    do_seq(8'h8D, 0, SEQ, 1'b1, 1'b0, 8'h00);
    end_check("R7", 8'h8D, 1);

    // R4 / R5 short low pulse early in the sequence blocks; R8 vol bits load anyway
    cur_req = "R4";
    do_seq(8'h82, 3, 2, 1'b1, 1'b0, 8'h00);
    end_check("R4", 8'h8E, 0);
    chk("R8", status & VOLM, 8'h02);

    // R5 the block flag was cleared by the CS rise
    cur_req = "R5";
    do_seq(8'h88, 0, 0, 1'b1, 1'b0, 8'h00);
    end_check("R5", 8'h88, 1);

    // R6 pin falls after the start: write still completes
    cur_req = "R6";
    do_seq(8'h84, 0, 0, 1'b0, 1'b0, 8'h00);
    end_check("R6", 8'h84, 1);

    // R7 clearing the lock with pin low is blocked
    cur_req = "R7";
    do_seq(8'h05, 0, SEQ, 1'b1, 1'b0, 8'h00);
    end_check("R7", 8'h85, 0);

    // R3 lock set, pin high: allowed
    cur_req = "R3";
    do_seq(8'h00, 0, 0, 1'b1, 1'b0, 8'h00);
    end_check("R3", 8'h00, 1);

    // R9 a second start while busy is ignored
    cur_req = "R9";
    do_seq(8'h0C, 0, 0, 1'b1, 1'b1, 8'h83);
    end_check("R9", 8'h0C, 1);

    // R10 start without the sequence flag is ignored
    cur_req = "R10";
    @(negedge clk); start = 1; act = 0; nv = 8'hFF;
    @(posedge clk); #6;
    chk("R10", {busy, status}, {1'b0, 8'h0C});
    @(negedge clk); start = 0;
    repeat (WRC + 2) @(negedge clk);
    chk("R10", {busy, status}, {1'b0, 8'h0C});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule